// File: doc/BRIEF.md
# Swizzling Buffer Address Generator

This block turns one vector buffer access into per-lane byte addresses. Each cycle it takes a 128-bit resource descriptor, a 32-bit scalar offset, a signed immediate, and for every lane a 32-bit element index, a 32-bit byte offset and an execute bit. It then computes, in parallel for all lanes, a 64-bit address. Two layouts are supported. The linear layout places records one stride apart. The swizzled layout interleaves groups of records at element granularity.

Each lane is also checked against the buffer bounds. Lanes that fail the check are reported in an out-of-bounds mask, so that their destination registers can be filled with zero. They are removed from the request mask, so that no memory traffic is issued for them. All three outputs are registered, and they appear one clock after the inputs are sampled.

Top module: `buf_addr_swz`

## Requirements
- R1: Descriptor fields (bit positions):
  - base address: [47:0]
  - stride: [61:48]
  - swizzle enable: [63]
  - record count: [95:64]
  - index-stride select: [97:96]
  - element-size select: [99:98]
  - lane-id add enable: [100]
  - format field: [104:101]

  All other bits are ignored.
- R2: The effective stride is the stride field. When lane-id add is set, it is instead (format << 14) + stride. When lane-id add is set, lane L uses index vidx + L. Otherwise it uses vidx alone.
- R3: With swizzle off, the buffer offset is off + stride_eff × idx.
- R4: With swizzle on:
  - The index stride is IS = 8 << isel and the element size is ES = 2 << esel.
  - The buffer offset is ((idx / IS) × stride_eff + (off / ES) × ES) × IS + (idx % IS) × ES + off % ES.
- R5: When the stride field is zero or swizzle is off, an active lane is out of bounds if its buffer offset is ≥ (records − soff), with that difference taken modulo 2^32.
- R6: When the stride field is non-zero and swizzle is on, an active lane is out of bounds if idx ≥ records or off ≥ stride_eff.
- R7: A lane that is active and in bounds gets the address base + soff + buffer offset, modulo 2^64. An inactive or out-of-bounds lane outputs address 0.
- R8: The request mask equals the execute mask with the out-of-bounds lanes cleared. A lane whose execute bit is 0 is never flagged out of bounds.
- R9: Outputs follow the inputs with exactly one clock of latency. While reset is held, all outputs are zero.
- R10: The immediate is sign-extended to 32 bits. The per-lane offset (voff + imm) and the per-lane index both wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsrc_i | input | 128 | Buffer resource descriptor |
| soff_i | input | 32 | Scalar byte offset |
| imm_i | input | IMM_W | Signed immediate byte offset |
| voff_i | input | LANES×32 | Per-lane byte offset, lane 0 in the low bits |
| vidx_i | input | LANES×32 | Per-lane element index |
| exec_i | input | LANES | Per-lane execute mask |
| addr_o | output | LANES×64 | Per-lane byte address |
| oob_o | output | LANES | Out-of-bounds lanes |
| req_o | output | LANES | Lanes that issue a request |

## Verification
Random descriptors are drawn with small offsets and indices, so that lanes straddle the record limit. This shows whether the bound compare and the request mask agree, lane by lane.

Directed patterns isolate particular behaviours:
- Swizzle on with stride zero separates the swizzled offset formula from the bound rule that applies to it.
- Lane-id add with a non-zero format field shows whether the stride widening and the lane bias are applied.
- A scalar offset larger than the record count exposes whether the limit wraps.
- A negative immediate shows whether the sign extension and the 32-bit offset wrap are honoured.

// File: rtl/buf_addr_swz.sv
module buf_addr_swz #(
  parameter int LANES = 8,
  parameter int IMM_W = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [127:0]          rsrc_i,
  input  logic [31:0]           soff_i,
  input  logic [IMM_W-1:0]      imm_i,
  input  logic [LANES*32-1:0]   voff_i,
  input  logic [LANES*32-1:0]   vidx_i,
  input  logic [LANES-1:0]      exec_i,
  output logic [LANES*64-1:0]   addr_o,
  output logic [LANES-1:0]      oob_o,
  output logic [LANES-1:0]      req_o
);
  localparam int DW = 32;
  localparam int AW = 64;

  logic [47:0] base;
  logic [13:0] stride;
  logic        swz;
  logic [31:0] records;
  logic [1:0]  isel, esel;
  logic        add_tid;
  logic [3:0]  fmt;

  assign base    = rsrc_i[47:0];
  assign stride  = rsrc_i[61:48];
  assign swz     = rsrc_i[63];
  assign records = rsrc_i[95:64];
  assign isel    = rsrc_i[97:96];
  assign esel    = rsrc_i[99:98];
  assign add_tid = rsrc_i[100];
  assign fmt     = rsrc_i[104:101];

  logic [17:0] eff_stride;
  logic [DW-1:0] imm_ext, limit;
  logic        lin_rule;
  logic [2:0]  ish;
  logic [2:0]  esh;

  assign eff_stride = add_tid ? ({fmt, 14'd0} + {4'd0, stride}) : {4'd0, stride};
  assign imm_ext    = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign limit      = records - soff_i;
  assign lin_rule   = (stride == 14'd0) || !swz;
  assign ish        = 3'd3 + {1'b0, isel};
  assign esh        = 3'd1 + {1'b0, esel};

  logic [LANES*AW-1:0] addr_n;
  logic [LANES-1:0]    oob_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] idx, off, idx_q, idx_r, off_q, off_r;
    logic [AW-1:0] swz_off, lin_off, boff;
    logic          bad;

    always_comb begin
      idx     = vidx_i[l*DW +: DW] + (add_tid ? DW'(l) : '0);
      off     = voff_i[l*DW +: DW] + imm_ext;
      idx_q   = idx >> ish;
      idx_r   = idx & ((32'd1 << ish) - 32'd1);
      off_q   = off >> esh;
      off_r   = off & ((32'd1 << esh) - 32'd1);
      swz_off = ((AW'(idx_q) * AW'(eff_stride) + (AW'(off_q) << esh)) << ish)
              + (AW'(idx_r) << esh) + AW'(off_r);
      lin_off = AW'(off) + AW'(eff_stride) * AW'(idx);
      boff    = swz ? swz_off : lin_off;
      bad     = lin_rule ? (boff >= AW'(limit))
                         : ((idx >= records) || (AW'(off) >= AW'(eff_stride)));
      oob_n[l] = exec_i[l] & bad;
      addr_n[l*AW +: AW] = (exec_i[l] && !bad) ? (AW'(base) + AW'(soff_i) + boff) : '0;
    end
  end

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
      oob_o  <= '0;
      req_o  <= '0;
      live_q <= 1'b0;
    end else begin
      addr_o <= addr_n;
      oob_o  <= oob_n;
      req_o  <= exec_i & ~oob_n;
      live_q <= 1'b1;
    end
  end

  assert_req_oob_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & oob_o) == '0);

  assert_lanes_cover_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((req_o | oob_o) == $past(exec_i)));

  assert_oob_follows_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((oob_o & ~$past(exec_i)) == '0));

  assert_lin_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(lin_rule) && $past(limit) == '0) |-> ((req_o & $past(exec_i)) == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_idle_addr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_o[l] |-> (addr_o[l*AW +: AW] == '0));
  end
endmodule

// File: tb/sim_buf_addr_swz.sv
module sim_buf_addr_swz;
  localparam int LANES = 8;
  localparam int IMM_W = 13;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] rsrc;
  logic [31:0] soff;
  logic [IMM_W-1:0] imm;
  logic [LANES*32-1:0] voff, vidx;
  logic [LANES-1:0] exec_m;
  logic [LANES*64-1:0] addr;
  logic [LANES-1:0] oob, req;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buf_addr_swz #(.LANES(LANES), .IMM_W(IMM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rsrc_i(rsrc), .soff_i(soff), .imm_i(imm),
    .voff_i(voff), .vidx_i(vidx), .exec_i(exec_m),
    .addr_o(addr), .oob_o(oob), .req_o(req));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [127:0] mk_desc(logic [47:0] b, logic [13:0] st, logic sw,
      logic [31:0] rec, logic [1:0] is, logic [1:0] es, logic tid, logic [3:0] f);
    logic [127:0] d = '0;
    d[47:0] = b; d[61:48] = st; d[63] = sw; d[95:64] = rec;
    d[97:96] = is; d[99:98] = es; d[100] = tid; d[104:101] = f;
    return d;
  endfunction

  // reference model: returns {oob, address}
  function automatic void model(int l, output logic bad, output logic [63:0] a);
    logic [63:0] st, is, es, boff;
    logic [31:0] idx, off, imm32, lim;
    st = rsrc[100] ? ((64'(rsrc[104:101]) * 64'd16384) + 64'(rsrc[61:48])) : 64'(rsrc[61:48]);
    idx = vidx[l*32 +: 32] + (rsrc[100] ? 32'(l) : 32'd0);
    imm32 = 32'(signed'(imm));
    off = voff[l*32 +: 32] + imm32;
    if (rsrc[63]) begin
      is = 64'd8 << rsrc[97:96];
      es = 64'd2 << rsrc[99:98];
      boff = ((64'(idx) / is) * st + (64'(off) / es) * es) * is
           + (64'(idx) % is) * es + (64'(off) % es);
    end else
      boff = 64'(off) + st * 64'(idx);
    lim = rsrc[95:64] - soff;
    if (rsrc[61:48] == 14'd0 || !rsrc[63])
      bad = boff >= 64'(lim);
    else
      bad = (idx >= rsrc[95:64]) || (64'(off) >= st);
    bad = bad & exec_m[l];
    a = (exec_m[l] && !bad) ? 64'(rsrc[47:0]) + 64'(soff) + boff : 64'd0;
  endfunction

  task automatic check(string tag);
    logic bad;
    logic [63:0] ea;
    logic [LANES-1:0] eo, er;
    logic [LANES*64-1:0] ea_all;
    for (int l = 0; l < LANES; l++) begin
      model(l, bad, ea);
      eo[l] = bad;
      er[l] = exec_m[l] & ~bad;
      ea_all[l*64 +: 64] = ea;
    end
    @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      checks++;
      if (addr[l*64 +: 64] !== ea_all[l*64 +: 64]) begin
        failures++;
        $display("FAIL %s R7 lane %0d addr actual=%h expected=%h", tag, l,
                 addr[l*64 +: 64], ea_all[l*64 +: 64]);
      end
    end
    checks++;
    if (oob !== eo) begin
      failures++;
      $display("FAIL %s oob actual=%b expected=%b", tag, oob, eo);
    end
    checks++;
    if (req !== er) begin
      failures++;
      $display("FAIL %s R8 req actual=%b expected=%b", tag, req, er);
    end
  endtask

  task automatic rnd_lanes(int span);
    for (int l = 0; l < LANES; l++) begin
      voff[l*32 +: 32] = $urandom % span;
      vidx[l*32 +: 32] = $urandom % span;
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    rsrc = '0; soff = '0; imm = '0; voff = '0; vidx = '0; exec_m = '0;
    repeat (3) @(negedge clk);
    rsrc = mk_desc(48'h1234, 14'd16, 1'b0, 32'd1000, 2'd0, 2'd0, 1'b0, 4'd0);
    exec_m = '1;
    @(negedge clk);
    checks++;
    if (addr !== '0 || oob !== '0 || req !== '0) begin
      failures++;
      $display("FAIL R9 reset actual=%h/%b/%b expected=0", addr, oob, req);
    end
    rst_n = 1'b1;

    // R3 R1 linear, all lanes in bounds
    rsrc = mk_desc(48'h1000_0000, 14'd16, 1'b0, 32'hFFFF, 2'd0, 2'd0, 1'b0, 4'd0);
    rsrc[127:110] = 18'h3FFFF; // ignored bits
    soff = 32'd8; imm = 13'd4; exec_m = 8'hFF;
    for (int l = 0; l < LANES; l++) begin voff[l*32 +: 32] = 32'(l*4); vidx[l*32 +: 32] = 32'(l); end
    check("R3 R1 linear");

    // R5 linear bound straddle
    rsrc = mk_desc(48'h400, 14'd16, 1'b0, 32'd72, 2'd0, 2'd0, 1'b0, 4'd0);
    soff = 32'd8; imm = '0; exec_m = 8'hF7;
    check("R5 straddle");

    // R5 limit wraps when soff exceeds records
    rsrc = mk_desc(48'h400, 14'd4, 1'b0, 32'd10, 2'd0, 2'd0, 1'b0, 4'd0);
    soff = 32'd20;
    check("R5 wrap");

    // R4 R5 swizzle on, stride zero -> linear bound rule
    rsrc = mk_desc(48'h8000, 14'd0, 1'b1, 32'd40, 2'd1, 2'd1, 1'b0, 4'd0);
    soff = 32'd0; exec_m = 8'hFF;
    check("R4 R5 swz stride0");

    // R4 R6 swizzled with bounds by index and offset
    rsrc = mk_desc(48'h9000, 14'd12, 1'b1, 32'd5, 2'd0, 2'd1, 1'b0, 4'd0);
    for (int l = 0; l < LANES; l++) begin voff[l*32 +: 32] = 32'(l*2); vidx[l*32 +: 32] = 32'(l); end
    check("R4 R6 swz");

    // R2 lane-id add with format widening
    rsrc = mk_desc(48'hA000, 14'd3, 1'b0, 32'hFFFF_FFFF, 2'd0, 2'd0, 1'b1, 4'd2);
    check("R2 tid linear");
    rsrc = mk_desc(48'hA000, 14'd3, 1'b1, 32'd100, 2'd2, 2'd0, 1'b1, 4'd1);
    check("R2 R6 tid swz");

    // R10 negative immediate, offset wraps
    rsrc = mk_desc(48'hB000, 14'd8, 1'b0, 32'hFFFF_FFFF, 2'd0, 2'd0, 1'b0, 4'd0);
    imm = 13'h1FFC; // -4
    for (int l = 0; l < LANES; l++) begin voff[l*32 +: 32] = 32'(l); vidx[l*32 +: 32] = 32'd2; end
    check("R10 neg imm");
    imm = 13'h1000;
    rsrc = mk_desc(48'hB000, 14'd8, 1'b1, 32'd9, 2'd3, 2'd3, 1'b0, 4'd0);
    check("R10 R6 neg imm swz");

    // R8 inactive lanes never flagged
    rsrc = mk_desc(48'hC000, 14'd4, 1'b0, 32'd0, 2'd0, 2'd0, 1'b0, 4'd0);
    imm = '0; exec_m = 8'h5A;
    check("R8 all oob partial exec");
    exec_m = 8'h00;
    check("R8 no exec");

    // random mix
    for (int n = 0; n < 400; n++) begin
      rsrc = mk_desc({16'h0, $urandom}, 14'($urandom % 64), 1'($urandom), 32'($urandom % 512),
                     2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom));
      if (n % 8 == 0) rsrc[95:64] = $urandom;
      soff = $urandom % 64;
      imm = IMM_W'($urandom % 32) - IMM_W'(8);
      exec_m = LANES'($urandom);
      rnd_lanes((n % 5 == 0) ? 32'h7FFF_FFFF : 96);
      check(rsrc[63] ? "R4 R6 random" : "R3 R5 random");
    end

    // R9 reset clears outputs again
    rst_n = 1'b0;
    #1;
    checks++;
    if (addr !== '0 || oob !== '0 || req !== '0) begin
      failures++;
      $display("FAIL R9 rereset actual=%b/%b expected=0", oob, req);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule